// File: doc/BRIEF.md
# Two-Level TLB Tag Lookup

This block finds the translation entry for a virtual address in a TLB made of two parts. The first part is set-associative, with 8 ways of 256 sets. All of its entries share one page size, which the requester supplies with each lookup. The second part is a fully associative bank of 64 entries, and each of those entries carries its own page size. Every entry covers an even/odd pair of pages. Its stored tag holds the virtual address bits from bit 13 upward. Before the compare, the low bits of the tag that fall inside the page pair are ignored.

A lookup is offered on a valid/ready request channel. The whole search is combinational within the accepting cycle. The result (a hit flag and a flat entry index) is registered on a valid/ready response channel. A request is accepted only when the response register is empty or is being drained in the same cycle, so back-pressure on the response stalls the request side with no extra buffering.

Entries are loaded through a plain write port addressed by the same flat index that lookups report. Checking permissions, choosing a victim and invalidating entries are left to neighbouring logic. Both `req_ps` and `wr_ps` must lie between 12 and VA_W-10.

Top module: `tlb_dual_lookup`

## Requirements
- R1: After reset, rsp_valid, rsp_hit and rsp_index are 0, req_ready is 1, and every entry is empty, so lookups miss.
- R2: In the set-associative part, the page number is the address, cut to its low VA_W bits, shifted right by req_ps+1. The set is the low 8 bits of that page number. Addresses that differ only below bit req_ps+1 select the same entry.
- R3: The loaded tag wr_vtag holds address bits [VA_W-1:13]. An entry matches when the tag, shifted right by ps-12, equals the page number.
- R4: An entry hits only if its exists bit is 1 and either its global bit is 1 or its ASID equals req_asid.
- R5: The set-associative part has precedence. When it hits, its entry is reported even if a fully associative entry also matches.
- R6: Each fully associative entry compares using its own wr_ps, whatever the value of req_ps.
- R7: When several ways hit, the lowest way wins. When several fully associative entries hit and the first part misses, the lowest slot wins.
- R8: Flat index encoding: way*256+set for the first part and 2048+slot for the second. A miss reports index 0. Writes to an index of 2112 or above are ignored.
- R9: Request address bits 63 down to VA_W have no effect on the result.
- R10: A request accepted at a clock edge produces rsp_valid=1 after that edge. While rsp_valid=1 and rsp_ready=0, the response holds steady and req_ready is 0. req_ready = !rsp_valid || rsp_ready.
- R11: A lookup accepted in the same cycle as a write sees the entry contents from before that write. The written entry is visible to the lookups that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_va | input | 64 | Virtual address |
| req_asid | input | 10 | Current address-space ID |
| req_ps | input | 6 | Page size (log2 bytes) of the set-associative part |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_hit | output | 1 | An entry matched |
| rsp_index | output | 12 | Flat index of the matching entry, 0 on miss |
| wr_en | input | 1 | Load an entry |
| wr_index | input | 12 | Flat index of the entry to load |
| wr_exists | input | 1 | Exists bit to load |
| wr_global | input | 1 | Global bit to load |
| wr_asid | input | 10 | ASID to load |
| wr_vtag | input | 35 | Virtual tag, address bits [47:13] |
| wr_ps | input | 6 | Page size of a fully associative entry |

## Verification
The bench places the same address in both parts to check that the first part wins. A design with the wrong precedence would report an index of 2048 or above. It also loads duplicate matches in two ways and in two slots; a reversed priority encoder would return the higher index. Addresses are varied inside and outside the page pair and above the implemented width, and wide-page slots are looked up under a different request page size. An off-by-one in the tag shift, a set index taken from fixed bits, or use of the global page size for fully associative entries would turn hits into misses or the reverse. Stalled responses, and a write that lands in the same cycle as a lookup, show whether the result register holds steady and whether the lookup reads the old contents.

// File: rtl/tlb_dual_pkg.sv
package tlb_dual_pkg;
  localparam int ASID_W  = 10;
  localparam int PS_W    = 6;
  localparam int VA_IN_W = 64;
  localparam int TAG_LSB = 13;
  localparam int MIN_PS  = TAG_LSB - 1;
endpackage

// File: rtl/tlb_dual_sa_way.sv
module tlb_dual_sa_way
  import tlb_dual_pkg::*;
#(
  parameter int SETS  = 256,
  parameter int TAG_W = 35,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic              wr_exists,
  input  logic              wr_global,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [TAG_W-1:0]  va_tag,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [PS_W-1:0]   drop,
  output logic              hit
);
  logic [SETS-1:0]   exists_q;
  logic              global_q [SETS];
  logic [ASID_W-1:0] asid_q   [SETS];
  logic [TAG_W-1:0]  tag_q    [SETS];
  logic [TAG_W-1:0]  keep;

  always_ff @(posedge clk) begin
    if (!rst_n)     exists_q <= '0;
    else if (wr_en) exists_q[wr_set] <= wr_exists;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      global_q[wr_set] <= wr_global;
      asid_q[wr_set]   <= wr_asid;
      tag_q[wr_set]    <= wr_tag;
    end
  end

  // Tag bits below the page pair are ignored instead of shifting the tag.
  assign keep = {TAG_W{1'b1}} << drop;
  assign hit  = exists_q[rd_set]
              && (global_q[rd_set] || (asid_q[rd_set] == cur_asid))
              && (((tag_q[rd_set] ^ va_tag) & keep) == '0);
endmodule

// File: rtl/tlb_dual_fa_bank.sv
module tlb_dual_fa_bank
  import tlb_dual_pkg::*;
#(
  parameter int N     = 64,
  parameter int TAG_W = 35,
  localparam int SLOT_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_exists,
  input  logic              wr_global,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [PS_W-1:0]   wr_ps,
  input  logic [TAG_W-1:0]  va_tag,
  input  logic [ASID_W-1:0] cur_asid,
  output logic [N-1:0]      hit_vec
);
  for (genvar e = 0; e < N; e++) begin : g_ent
    logic              ex_q;
    logic              gl_q;
    logic [ASID_W-1:0] asid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [PS_W-1:0]   ps_q;
    logic [TAG_W-1:0]  keep;
    logic              sel;

    assign sel = wr_en && (wr_slot == SLOT_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n)   ex_q <= 1'b0;
      else if (sel) ex_q <= wr_exists;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        gl_q   <= wr_global;
        asid_q <= wr_asid;
        tag_q  <= wr_tag;
        ps_q   <= wr_ps;
      end
    end

    // Each entry masks its own page-pair bits from its own page size.
    assign keep       = {TAG_W{1'b1}} << (ps_q - PS_W'(MIN_PS));
    assign hit_vec[e] = ex_q && (gl_q || (asid_q == cur_asid))
                      && (((tag_q ^ va_tag) & keep) == '0);
  end
endmodule

// File: rtl/tlb_dual_first.sv
module tlb_dual_first #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_dual_lookup.sv
module tlb_dual_lookup
  import tlb_dual_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int SA_WAYS = 8,
  parameter int SA_SETS = 256,
  parameter int FA_N    = 64,
  localparam int TAG_W    = VA_W - TAG_LSB,
  localparam int SET_W    = $clog2(SA_SETS),
  localparam int WAY_W    = $clog2(SA_WAYS),
  localparam int FA_W     = (FA_N > 1) ? $clog2(FA_N) : 1,
  localparam int SA_TOTAL = SA_WAYS * SA_SETS,
  localparam int TOTAL    = SA_TOTAL + FA_N,
  localparam int IDX_W    = $clog2(TOTAL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_IN_W-1:0] req_va,
  input  logic [ASID_W-1:0]  req_asid,
  input  logic [PS_W-1:0]    req_ps,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_hit,
  output logic [IDX_W-1:0]   rsp_index,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_index,
  input  logic               wr_exists,
  input  logic               wr_global,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic [TAG_W-1:0]   wr_vtag,
  input  logic [PS_W-1:0]    wr_ps
);
  localparam logic [IDX_W-1:0] SA_BASE = IDX_W'(SA_TOTAL);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(TOTAL);

  logic [VA_W-1:0]  va_m;
  logic [VA_W-1:0]  pn;
  logic [TAG_W-1:0] va_tag;
  logic [SET_W-1:0] set;
  logic [PS_W-1:0]  drop;
  logic             fire;

  assign va_m   = req_va[VA_W-1:0];
  assign va_tag = va_m[VA_W-1:TAG_LSB];
  assign pn     = va_m >> (req_ps + PS_W'(1));
  assign set    = pn[SET_W-1:0];
  assign drop   = req_ps - PS_W'(MIN_PS);

  logic unused_bits;
  assign unused_bits = ^{req_va[VA_IN_W-1:VA_W], pn[VA_W-1:SET_W]};

  // Write decode
  logic             wr_sa, wr_fa;
  logic [WAY_W-1:0] wr_way;
  logic [SET_W-1:0] wr_set;
  logic [FA_W-1:0]  wr_slot;
  logic [IDX_W-1:0] wr_off;

  assign wr_sa   = wr_en && (wr_index < SA_BASE);
  assign wr_fa   = wr_en && (wr_index >= SA_BASE) && (wr_index < TOP_IDX);
  assign wr_way  = wr_index[SET_W +: WAY_W];
  assign wr_set  = wr_index[SET_W-1:0];
  assign wr_off  = wr_index - SA_BASE;
  assign wr_slot = wr_off[FA_W-1:0];

  // Set-associative part
  logic [SA_WAYS-1:0] sa_hits;
  for (genvar w = 0; w < SA_WAYS; w++) begin : g_way
    tlb_dual_sa_way #(.SETS(SA_SETS), .TAG_W(TAG_W)) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_sa && (wr_way == WAY_W'(w))),
      .wr_set   (wr_set),
      .wr_exists(wr_exists),
      .wr_global(wr_global),
      .wr_asid  (wr_asid),
      .wr_tag   (wr_vtag),
      .rd_set   (set),
      .va_tag   (va_tag),
      .cur_asid (req_asid),
      .drop     (drop),
      .hit      (sa_hits[w])
    );
  end

  // Fully associative part
  logic [FA_N-1:0] fa_hits;
  tlb_dual_fa_bank #(.N(FA_N), .TAG_W(TAG_W)) u_fa (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_fa),
    .wr_slot  (wr_slot),
    .wr_exists(wr_exists),
    .wr_global(wr_global),
    .wr_asid  (wr_asid),
    .wr_tag   (wr_vtag),
    .wr_ps    (wr_ps),
    .va_tag   (va_tag),
    .cur_asid (req_asid),
    .hit_vec  (fa_hits)
  );

  logic             sa_any, fa_any;
  logic [WAY_W-1:0] sa_way;
  logic [FA_W-1:0]  fa_idx;

  tlb_dual_first #(.N(SA_WAYS)) u_sa_pick (.req(sa_hits), .any(sa_any), .idx(sa_way));
  tlb_dual_first #(.N(FA_N))    u_fa_pick (.req(fa_hits), .any(fa_any), .idx(fa_idx));

  logic             nx_hit;
  logic [IDX_W-1:0] nx_idx;

  always_comb begin
    nx_hit = sa_any || fa_any;
    if (sa_any)      nx_idx = IDX_W'({sa_way, set});
    else if (fa_any) nx_idx = SA_BASE + IDX_W'(fa_idx);
    else             nx_idx = '0;
  end

  // Response register with back-pressure
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_index <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= nx_hit;
      rsp_index <= nx_idx;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_index)); // R10
  AST_ACCEPT_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid); // R10
  AST_SA_PRECEDES: assert property (@(posedge clk) disable iff (!rst_n)
    fire && sa_any |=> rsp_hit && (rsp_index < SA_BASE)); // R5
  AST_FA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !sa_any && fa_any |=> rsp_hit && (rsp_index >= SA_BASE) && (rsp_index < TOP_IDX)); // R6
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_index == '0); // R8
endmodule

// File: tb/test_tlb_dual_lookup.sv
`timescale 1ns/1ps
module test_tlb_dual_lookup;
  localparam int WAYS = 8, SETS = 256, FA_N = 64;
  localparam int SA_TOTAL = WAYS * SETS, TOTAL = SA_TOTAL + FA_N;

  logic        clk, rst_n;
  logic        req_valid, req_ready, rsp_valid, rsp_ready, rsp_hit;
  logic [63:0] req_va;
  logic [9:0]  req_asid;
  logic [5:0]  req_ps;
  logic [11:0] rsp_index;
  logic        wr_en, wr_exists, wr_global;
  logic [11:0] wr_index;
  logic [9:0]  wr_asid;
  logic [34:0] wr_vtag;
  logic [5:0]  wr_ps;

  tlb_dual_lookup i_tlb_dual_lookup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_asid(req_asid), .req_ps(req_ps),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_index(rsp_index),
    .wr_en(wr_en), .wr_index(wr_index), .wr_exists(wr_exists), .wr_global(wr_global),
    .wr_asid(wr_asid), .wr_vtag(wr_vtag), .wr_ps(wr_ps)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  bit        m_e [TOTAL];
  bit        m_g [TOTAL];
  bit [9:0]  m_a [TOTAL];
  bit [34:0] m_t [TOTAL];
  int        m_p [TOTAL];

  task automatic chk(string rq, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int set_of(bit [63:0] va, int ps);
    bit [47:0] v = va[47:0];
    bit [47:0] p = v >> (ps + 1);
    return int'(p[7:0]);
  endfunction

  task automatic model(input bit [63:0] va, input int asid, input int ps,
                       output bit hit, output int idx);
    bit [47:0] v;
    bit [47:0] pn;
    int k;
    v = va[47:0];
    hit = 0;
    idx = 0;
    pn = v >> (ps + 1);
    for (int w = 0; w < WAYS; w++) begin
      k = w * SETS + int'(pn[7:0]);
      if (!hit && m_e[k] && (m_g[k] || m_a[k] == asid[9:0]) &&
          ((48'(m_t[k]) >> (ps - 12)) == pn)) begin
        hit = 1;
        idx = k;
      end
    end
    for (int s = 0; s < FA_N; s++) begin
      k = SA_TOTAL + s;
      if (!hit && m_e[k] && (m_g[k] || m_a[k] == asid[9:0]) &&
          ((48'(m_t[k]) >> (m_p[k] - 12)) == (v >> (m_p[k] + 1)))) begin
        hit = 1;
        idx = k;
      end
    end
  endtask

  task automatic do_write(int idx, bit [63:0] va, int ps, int asid, bit g, bit e);
    @(negedge clk);
    wr_en = 1; wr_index = idx[11:0]; wr_vtag = va[47:13]; wr_ps = ps[5:0];
    wr_asid = asid[9:0]; wr_global = g; wr_exists = e;
    @(negedge clk);
    wr_en = 0;
    if (idx < TOTAL) begin
      m_e[idx] = e; m_g[idx] = g; m_a[idx] = asid[9:0]; m_t[idx] = va[47:13]; m_p[idx] = ps;
    end
  endtask

  task automatic issue(bit [63:0] va, int asid, int ps);
    @(negedge clk);
    req_valid = 1; req_va = va; req_asid = asid[9:0]; req_ps = ps[5:0]; rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_rsp(string rq, bit eh, int ei);
    chk(rq, "rsp_valid", rsp_valid, 1);
    chk(rq, "rsp_hit", rsp_hit, eh);
    chk(rq, "rsp_index", rsp_index, eh ? ei : 0);
  endtask

  task automatic look_model(bit [63:0] va, int asid, int ps, string rq);
    bit eh;
    int ei;
    model(va, asid, ps, eh, ei);
    issue(va, asid, ps);
    expect_rsp(rq, eh, ei);
  endtask

  localparam bit [63:0] VA1 = 64'h0012_3456_8000;
  localparam bit [63:0] VA2 = 64'h00AB_CDEF_0000;
  localparam bit [63:0] VA3 = 64'h0765_4000_0000;
  localparam bit [63:0] VA4 = 64'h0031_4159_2000;
  localparam bit [63:0] VA5 = 64'h0027_1828_1000;
  localparam bit [63:0] VA6 = 64'h0051_7700_6000;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit [63:0] pool [16];
    int pss [4];
    int fps [4];
    bit eh;
    int ei;
    int sa_a, sa_b;

    pss = '{12, 13, 14, 15};
    fps = '{12, 14, 16, 21};
    void'($urandom(32'h5eed_0421));
    rst_n = 0; req_valid = 0; req_va = '0; req_asid = '0; req_ps = 6'd13; rsp_ready = 1;
    wr_en = 0; wr_index = '0; wr_exists = 0; wr_global = 0; wr_asid = '0; wr_vtag = '0; wr_ps = 6'd12;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "rsp_hit", rsp_hit, 0);
    chk("R1", "rsp_index", rsp_index, 0);
    chk("R1", "req_ready", req_ready, 1);

    issue(VA1, 5, 13);
    expect_rsp("R1 empty", 0, 0);

    // R2 / R3 / R8: direct set-associative hit
    do_write(3 * SETS + set_of(VA1, 13), VA1, 13, 5, 0, 1);
    issue(VA1, 5, 13);
    expect_rsp("R8", 1, 3 * SETS + set_of(VA1, 13));
    issue(VA1 ^ 64'h2000, 5, 13);
    expect_rsp("R3 page pair", 1, 3 * SETS + set_of(VA1, 13));
    issue(VA1 ^ 64'h4000, 5, 13);
    expect_rsp("R2 other set", 0, 0);

    // R4
    issue(VA1, 6, 13);
    expect_rsp("R4 asid", 0, 0);
    do_write(1 * SETS + set_of(VA2, 13), VA2, 13, 7, 1, 1);
    issue(VA2, 0, 13);
    expect_rsp("R4 global", 1, 1 * SETS + set_of(VA2, 13));
    do_write(3 * SETS + set_of(VA1, 13), VA1, 13, 5, 0, 0);
    issue(VA1, 5, 13);
    expect_rsp("R4 exists", 0, 0);

    // R5 then R6
    do_write(3 * SETS + set_of(VA1, 13), VA1, 13, 5, 0, 1);
    do_write(SA_TOTAL + 5, VA1, 13, 5, 0, 1);
    issue(VA1, 5, 13);
    expect_rsp("R5", 1, 3 * SETS + set_of(VA1, 13));
    do_write(3 * SETS + set_of(VA1, 13), VA1, 13, 5, 0, 0);
    issue(VA1, 5, 13);
    expect_rsp("R6 fallback", 1, SA_TOTAL + 5);

    do_write(SA_TOTAL + 9, VA3, 21, 2, 1, 1);
    issue(VA3 ^ 64'h3A_5000, 4, 12);
    expect_rsp("R6 own ps", 1, SA_TOTAL + 9);
    issue(VA3 ^ 64'h40_0000, 4, 12);
    expect_rsp("R6 outside", 0, 0);

    // R7
    sa_a = 6 * SETS + set_of(VA4, 13);
    sa_b = 2 * SETS + set_of(VA4, 13);
    do_write(sa_a, VA4, 13, 5, 0, 1);
    do_write(sa_b, VA4, 13, 5, 0, 1);
    issue(VA4, 5, 13);
    expect_rsp("R7 ways", 1, sa_b);
    do_write(SA_TOTAL + 40, VA5, 14, 0, 1, 1);
    do_write(SA_TOTAL + 12, VA5, 14, 0, 1, 1);
    issue(VA5, 9, 13);
    expect_rsp("R7 slots", 1, SA_TOTAL + 12);

    // R9
    issue(VA4 | 64'hABCD_0000_0000_0000, 5, 13);
    expect_rsp("R9", 1, sa_b);

    // R8: out-of-range write ignored
    do_write(TOTAL + 3, VA6, 13, 1, 1, 1);
    issue(VA6, 1, 13);
    expect_rsp("R8 bad index", 0, 0);

    // R10 back-pressure
    @(negedge clk);
    req_valid = 1; req_va = VA2; req_asid = '0; req_ps = 6'd13; rsp_ready = 0;
    @(negedge clk);
    model(VA6, 0, 13, eh, ei);
    req_va = VA6;
    chk("R10", "req_ready", req_ready, 0);
    expect_rsp("R10 held", 1, 1 * SETS + set_of(VA2, 13));
    repeat (2) begin
      @(negedge clk);
      chk("R10", "req_ready", req_ready, 0);
      expect_rsp("R10 held", 1, 1 * SETS + set_of(VA2, 13));
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    expect_rsp("R10 next", eh, ei);
    @(negedge clk);
    chk("R10", "rsp_valid drained", rsp_valid, 0);

    // R11 same-cycle write and lookup
    @(negedge clk);
    wr_en = 1; wr_index = 12'(set_of(VA6, 13)); wr_vtag = VA6[47:13]; wr_ps = 6'd13;
    wr_asid = 10'd1; wr_global = 0; wr_exists = 1;
    req_valid = 1; req_va = VA6; req_asid = 10'd1; req_ps = 6'd13; rsp_ready = 1;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    expect_rsp("R11 old", 0, 0);
    m_e[set_of(VA6, 13)] = 1; m_g[set_of(VA6, 13)] = 0; m_a[set_of(VA6, 13)] = 10'd1;
    m_t[set_of(VA6, 13)] = VA6[47:13]; m_p[set_of(VA6, 13)] = 13;
    issue(VA6, 1, 13);
    expect_rsp("R11 new", 1, set_of(VA6, 13));

    // Random phase against the bench model
    for (int i = 0; i < 16; i++) pool[i] = {16'h0, 16'($urandom), $urandom};
    for (int it = 0; it < 600; it++) begin
      int p, g, a;
      bit [63:0] va;
      p = int'($urandom % 16);
      g = pss[$urandom % 4];
      a = 1 + int'($urandom % 3);
      if ($urandom % 3 == 0) begin
        if ($urandom % 2 == 0)
          do_write(int'($urandom % WAYS) * SETS + set_of(pool[p], g), pool[p], g, a,
                   ($urandom % 4) == 0, ($urandom % 8) != 0);
        else
          do_write(SA_TOTAL + int'($urandom % FA_N), pool[p], fps[$urandom % 4], a,
                   ($urandom % 4) == 0, ($urandom % 8) != 0);
      end else begin
        va = pool[p] ^ 64'($urandom & 32'hFFF);
        if ($urandom % 4 == 0) va = va | {16'($urandom), 48'h0};
        look_model(va, a, g, "R2 R3 R4 R5 R6 R7 R9 random");
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule